// File: doc/BRIEF.md
# Region Memory Firewall

This block sits in front of one memory range and filters each access against a small table of base regions. Every request carries these fields:

- an offset into the protected range;
- a context identifier (CID, 0 to 7);
- a secure flag, a privilege flag and a read/write flag.

The block answers each request with a grant or a block pulse, one cycle after the request. Matching uses only a window of offset bits: the bits below the granularity exponent are ignored, and so is everything above the configured window width.

Software sets the block up over a plain 32-bit register bus. Each region carries:

- an enable, a secure-only attribute and an encryption attribute;
- a per-CID privilege-required mask;
- an inclusive start and end offset;
- per-CID read and write enables.

The first blocked access is recorded until software clears it. A sticky global lock freezes the whole configuration. Any attempt to change a frozen register, and any self-contradicting region setting, raises a configuration fault flag.

Top module: `memfw_top`

## Requirements
- R1: After reset, `acc_grant` and `acc_block` are low, the control word, the fault status and every region register read 0. The word at 0xFF0 reads `{WIN_W[7:0], GRAN_LOG2[7:0], 8'h00, NUM_RGN[7:0]}`.
- R2: Region n (1..NUM_RGN) owns four words at 0x40*n. The words sit at these offsets:
  - +0x0 is the attribute word: bit 0 enable, bit 8 secure-only, bit 15 encryption, bits 23:16 privilege-required per CID.
  - +0x4 is the start offset.
  - +0x8 is the inclusive end offset. Start and end each keep only bits GRAN_LOG2+WIN_W-1:GRAN_LOG2.
  - +0xC is the CID word: read enables in bits 7:0, write enables in bits 23:16.

  All other bits read 0. A read pulse on `reg_rd` loads `reg_rdata` at that clock edge.
- R3: For every cycle with `acc_valid` high, exactly one of `acc_grant`/`acc_block` is high in the next cycle. Both are low after a cycle without a request.
- R4: An access hits a region when the region is enabled and the access's window bits lie between the start and end window bits, both inclusive; offset bits below the granularity are ignored. An access that hits no region is blocked.
- R5: A read by CID c needs bit c of the hit region's CID word. A write needs bit 16+c.
- R6: When bit 16+c of the hit region's attribute word is set, an access by CID c is granted only with `acc_priv` high.
- R7: When the hit region's secure-only bit is set, an access is granted only with `acc_sec` high.
- R8: When several enabled regions hit, the lowest-numbered one alone decides.
- R9: A write of an attribute word with bit 15 set and bit 8 clear is discarded. It sets the configuration fault, which is bit 0 of the status word at 0x08.
- R10: Writing 1 to bit 0 of the control word at 0x00 sets the lock. Only reset clears it.
- R11: While locked, writes to region registers or the control word leave them unchanged and set status bit 0. Reads and access checking go on as before.
- R12: The first blocked access sets status bit 1 and is captured at two addresses, and later blocked accesses leave the capture unchanged:
  - at 0x20: CID in bits 2:0, write in bit 4, secure in bit 5, privilege in bit 6;
  - at 0x24: its full offset.
- R13: Writing 1 to bit 0 or bit 1 of the clear word at 0x0C clears the matching status bit, also while locked. The next blocked access after a clear is captured afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, loaded on a read strobe |
| acc_valid | input | 1 | Access request present |
| acc_ofs | input | GRAN_LOG2+WIN_W | Access offset into the protected range |
| acc_cid | input | 3 | Context identifier of the access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_sec | input | 1 | Access is secure |
| acc_priv | input | 1 | Access is privileged |
| acc_grant | output | 1 | Access granted (one cycle after request) |
| acc_block | output | 1 | Access blocked (one cycle after request) |

## Verification
The bench builds the block with three regions, a 16-byte granularity (GRAN_LOG2 = 4) and a six-bit window, so offsets are ten bits wide. The small granule lets the bench aim at the exact first and last offsets of a region and at offsets one granule outside it, while setting sub-granule bits that must be ignored. Three regions leave room for two overlapping ones, where the lower number must decide, plus a spare region for the rejected encryption setting.

// File: rtl/memfw_pkg.sv
package memfw_pkg;

   localparam int unsigned CID_NUM = 8;
   localparam int unsigned CID_W   = 3;
   localparam int unsigned RAW     = 12;

   // global word addresses
   localparam logic [RAW-1:0] A_CTRL  = 12'h000;
   localparam logic [RAW-1:0] A_FSTAT = 12'h008;
   localparam logic [RAW-1:0] A_FCLR  = 12'h00C;
   localparam logic [RAW-1:0] A_FINFO = 12'h020;
   localparam logic [RAW-1:0] A_FOFS  = 12'h024;
   localparam logic [RAW-1:0] A_HWCFG = 12'hFF0;

   // word offsets inside a region group
   localparam logic [5:0] W_ATTR  = 6'h00;
   localparam logic [5:0] W_START = 6'h04;
   localparam logic [5:0] W_END   = 6'h08;
   localparam logic [5:0] W_CID   = 6'h0C;

   // field positions
   localparam int unsigned B_EN   = 0;
   localparam int unsigned B_SEC  = 8;
   localparam int unsigned B_ENC  = 15;
   localparam int unsigned B_PRIV = 16;
   localparam int unsigned B_RD   = 0;
   localparam int unsigned B_WR   = 16;

   typedef struct packed {
      logic               en;
      logic               sec;
      logic               enc;
      logic [CID_NUM-1:0] priv;
      logic [CID_NUM-1:0] rd;
      logic [CID_NUM-1:0] wr;
   } rgn_attr_t;

   typedef struct packed {
      logic [CID_W-1:0] cid;
      logic             wr;
      logic             sec;
      logic             priv;
   } acc_tag_t;

endpackage

// File: rtl/memfw_regfile.sv
module memfw_regfile
   import memfw_pkg::*;
#(
   parameter int unsigned NUM_RGN   = 4,
   parameter int unsigned GRAN_LOG2 = 12,
   parameter int unsigned WIN_W     = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic                        reg_rd,
   input  logic [RAW-1:0]              reg_addr,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   output rgn_attr_t                   attr_o [NUM_RGN],
   output logic [WIN_W-1:0]            lo_o   [NUM_RGN],
   output logic [WIN_W-1:0]            hi_o   [NUM_RGN],
   output logic                        lock_o,
   output logic                        cfg_fault_o,
   output logic                        port_clr_o,
   input  logic                        fault_flag_i,
   input  acc_tag_t                    fault_tag_i,
   input  logic [GRAN_LOG2+WIN_W-1:0]  fault_ofs_i
);

   localparam int unsigned OFS_W = GRAN_LOG2 + WIN_W;
   localparam int unsigned TOP   = OFS_W - 1;

   logic [5:0]  sel_rgn;
   logic [5:0]  sel_word;
   logic        in_rgn;
   logic        ctrl_wr;
   logic        rgn_wr;
   logic        clr_wr;
   logic        denied_wr;
   logic        bad_enc;
   logic [31:0] rd_val;
   logic        unused_wdata;

   assign sel_rgn   = reg_addr[11:6];
   assign sel_word  = reg_addr[5:0];
   assign in_rgn    = (sel_rgn != 6'd0) && (32'(sel_rgn) <= NUM_RGN);
   assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
   assign rgn_wr    = reg_wr && in_rgn;
   assign clr_wr    = reg_wr && (reg_addr == A_FCLR);
   assign denied_wr = lock_o && (ctrl_wr || rgn_wr);
   assign bad_enc   = rgn_wr && (sel_word == W_ATTR) &&
                      reg_wdata[B_ENC] && !reg_wdata[B_SEC];
   assign port_clr_o   = clr_wr && reg_wdata[1];
   assign unused_wdata = ^reg_wdata;

   // lock and configuration fault
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_o      <= 1'b0;
         cfg_fault_o <= 1'b0;
      end else begin
         if (ctrl_wr && reg_wdata[0])
            lock_o <= 1'b1;
         if (denied_wr || bad_enc)
            cfg_fault_o <= 1'b1;
         else if (clr_wr && reg_wdata[0])
            cfg_fault_o <= 1'b0;
      end
   end

   // one register group per region
   generate
      for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
         logic we;
         assign we = rgn_wr && !lock_o && (32'(sel_rgn) == r + 1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               attr_o[r] <= '0;
               lo_o[r]   <= '0;
               hi_o[r]   <= '0;
            end else if (we) begin
               case (sel_word)
                  W_ATTR: begin
                     if (!(reg_wdata[B_ENC] && !reg_wdata[B_SEC])) begin
                        attr_o[r].en   <= reg_wdata[B_EN];
                        attr_o[r].sec  <= reg_wdata[B_SEC];
                        attr_o[r].enc  <= reg_wdata[B_ENC];
                        attr_o[r].priv <= reg_wdata[B_PRIV +: CID_NUM];
                     end
                  end
                  W_START: lo_o[r] <= reg_wdata[TOP:GRAN_LOG2];
                  W_END:   hi_o[r] <= reg_wdata[TOP:GRAN_LOG2];
                  W_CID: begin
                     attr_o[r].rd <= reg_wdata[B_RD +: CID_NUM];
                     attr_o[r].wr <= reg_wdata[B_WR +: CID_NUM];
                  end
                  default: ;
               endcase
            end
         end

         p_no_open_enc_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            attr_o[r].enc |-> attr_o[r].sec);
         p_frozen_r11 : assert property (@(posedge clk) disable iff (!rst_n)
            lock_o |=> ($stable(attr_o[r]) && $stable(lo_o[r]) && $stable(hi_o[r])));
      end
   endgenerate

   // read mux
   always_comb begin
      rd_val = '0;
      if (in_rgn) begin
         for (int unsigned r = 0; r < NUM_RGN; r++) begin
            if (32'(sel_rgn) == r + 1) begin
               case (sel_word)
                  W_ATTR: begin
                     rd_val[B_EN]               = attr_o[r].en;
                     rd_val[B_SEC]              = attr_o[r].sec;
                     rd_val[B_ENC]              = attr_o[r].enc;
                     rd_val[B_PRIV +: CID_NUM]  = attr_o[r].priv;
                  end
                  W_START: rd_val[TOP:GRAN_LOG2] = lo_o[r];
                  W_END:   rd_val[TOP:GRAN_LOG2] = hi_o[r];
                  W_CID: begin
                     rd_val[B_RD +: CID_NUM] = attr_o[r].rd;
                     rd_val[B_WR +: CID_NUM] = attr_o[r].wr;
                  end
                  default: ;
               endcase
            end
         end
      end else begin
         case (reg_addr)
            A_CTRL:  rd_val[0] = lock_o;
            A_FSTAT: rd_val[1:0] = {fault_flag_i, cfg_fault_o};
            A_FINFO: begin
               rd_val[CID_W-1:0] = fault_tag_i.cid;
               rd_val[4]         = fault_tag_i.wr;
               rd_val[5]         = fault_tag_i.sec;
               rd_val[6]         = fault_tag_i.priv;
            end
            A_FOFS:  rd_val[TOP:0] = fault_ofs_i;
            A_HWCFG: rd_val = {8'(WIN_W), 8'(GRAN_LOG2), 8'h00, 8'(NUM_RGN)};
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rdata <= '0;
      else if (reg_rd)
         reg_rdata <= rd_val;
   end

   p_lock_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |=> lock_o);
   p_locked_wr_flags_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && rgn_wr) |=> cfg_fault_o);

endmodule

// File: rtl/memfw_judge.sv
module memfw_judge
   import memfw_pkg::*;
#(
   parameter int unsigned NUM_RGN   = 4,
   parameter int unsigned GRAN_LOG2 = 12,
   parameter int unsigned WIN_W     = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  rgn_attr_t                   attr_i [NUM_RGN],
   input  logic [WIN_W-1:0]            lo_i   [NUM_RGN],
   input  logic [WIN_W-1:0]            hi_i   [NUM_RGN],
   input  logic                        acc_valid,
   input  logic [GRAN_LOG2+WIN_W-1:0]  acc_ofs,
   input  logic [CID_W-1:0]            acc_cid,
   input  logic                        acc_write,
   input  logic                        acc_sec,
   input  logic                        acc_priv,
   output logic                        grant_o,
   output logic                        block_o,
   output logic                        deny_now_o
);

   localparam int unsigned IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;

   logic [WIN_W-1:0]   win;
   logic [NUM_RGN-1:0] hit;
   logic [NUM_RGN-1:0] unused_enc;
   logic               unused_low;
   logic               found;
   logic [IDX_W-1:0]   pick;
   rgn_attr_t          sel;
   logic               perm_ok;
   logic               priv_ok;
   logic               sec_ok;
   logic               allow;

   assign win        = acc_ofs[GRAN_LOG2 +: WIN_W];
   assign unused_low = ^acc_ofs[GRAN_LOG2-1:0];

   generate
      for (genvar r = 0; r < NUM_RGN; r++) begin : g_hit
         assign hit[r] = attr_i[r].en && (win >= lo_i[r]) && (win <= hi_i[r]);
         assign unused_enc[r] = attr_i[r].enc;
      end
   endgenerate

   // lowest-numbered hit decides
   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int r = int'(NUM_RGN) - 1; r >= 0; r--) begin
         if (hit[r]) begin
            found = 1'b1;
            pick  = IDX_W'(r);
         end
      end
   end

   assign sel     = attr_i[pick];
   assign perm_ok = acc_write ? sel.wr[acc_cid] : sel.rd[acc_cid];
   assign priv_ok = !sel.priv[acc_cid] || acc_priv;
   assign sec_ok  = !sel.sec || acc_sec;
   assign allow   = found && perm_ok && priv_ok && sec_ok;
   assign deny_now_o = acc_valid && !allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_o <= 1'b0;
         block_o <= 1'b0;
      end else begin
         grant_o <= acc_valid && allow;
         block_o <= deny_now_o;
      end
   end

   p_one_verdict_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (grant_o ^ block_o));
   p_no_idle_verdict_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !(grant_o || block_o));
   p_nomatch_blocks_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !found) |=> block_o);
   p_secure_only_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && found && sel.sec && !acc_sec) |=> block_o);

endmodule

// File: rtl/memfw_fault_rec.sv
module memfw_fault_rec
   import memfw_pkg::*;
#(
   parameter int unsigned OFS_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             deny_i,
   input  acc_tag_t         tag_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic             clr_i,
   output logic             flag_o,
   output acc_tag_t         tag_o,
   output logic [OFS_W-1:0] ofs_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         tag_o  <= '0;
         ofs_o  <= '0;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end else if (deny_i && !flag_o) begin
         flag_o <= 1'b1;
         tag_o  <= tag_i;
         ofs_o  <= ofs_i;
      end
   end

   p_capture_hold_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> (flag_o && $stable(tag_o) && $stable(ofs_o)));
   p_clear_wins_r13 : assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !flag_o);

endmodule

// File: rtl/memfw_top.sv
module memfw_top
   import memfw_pkg::*;
#(
   parameter int unsigned NUM_RGN   = 4,
   parameter int unsigned GRAN_LOG2 = 12,
   parameter int unsigned WIN_W     = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic                        reg_rd,
   input  logic [11:0]                 reg_addr,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   input  logic                        acc_valid,
   input  logic [GRAN_LOG2+WIN_W-1:0]  acc_ofs,
   input  logic [2:0]                  acc_cid,
   input  logic                        acc_write,
   input  logic                        acc_sec,
   input  logic                        acc_priv,
   output logic                        acc_grant,
   output logic                        acc_block
);

   localparam int unsigned OFS_W = GRAN_LOG2 + WIN_W;

   generate
      if (NUM_RGN < 1 || NUM_RGN > 62) begin : g_bad_nrgn
         $error("memfw_top: NUM_RGN must lie in 1..62");
      end
      if (WIN_W < 1) begin : g_bad_win
         $error("memfw_top: WIN_W must be at least 1");
      end
      if (GRAN_LOG2 < 1 || OFS_W > 32) begin : g_bad_ofs
         $error("memfw_top: need GRAN_LOG2 >= 1 and GRAN_LOG2 + WIN_W <= 32");
      end
   endgenerate

   rgn_attr_t        attr [NUM_RGN];
   logic [WIN_W-1:0] lo   [NUM_RGN];
   logic [WIN_W-1:0] hi   [NUM_RGN];
   logic             lock;
   logic             cfg_fault;
   logic             port_clr;
   logic             deny_now;
   logic             flt_flag;
   acc_tag_t         flt_tag;
   logic [OFS_W-1:0] flt_ofs;
   acc_tag_t         cur_tag;

   assign cur_tag.cid  = acc_cid;
   assign cur_tag.wr   = acc_write;
   assign cur_tag.sec  = acc_sec;
   assign cur_tag.priv = acc_priv;

   memfw_regfile #(
      .NUM_RGN   (NUM_RGN),
      .GRAN_LOG2 (GRAN_LOG2),
      .WIN_W     (WIN_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_rd       (reg_rd),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .attr_o       (attr),
      .lo_o         (lo),
      .hi_o         (hi),
      .lock_o       (lock),
      .cfg_fault_o  (cfg_fault),
      .port_clr_o   (port_clr),
      .fault_flag_i (flt_flag),
      .fault_tag_i  (flt_tag),
      .fault_ofs_i  (flt_ofs)
   );

   memfw_judge #(
      .NUM_RGN   (NUM_RGN),
      .GRAN_LOG2 (GRAN_LOG2),
      .WIN_W     (WIN_W)
   ) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .attr_i     (attr),
      .lo_i       (lo),
      .hi_i       (hi),
      .acc_valid  (acc_valid),
      .acc_ofs    (acc_ofs),
      .acc_cid    (acc_cid),
      .acc_write  (acc_write),
      .acc_sec    (acc_sec),
      .acc_priv   (acc_priv),
      .grant_o    (acc_grant),
      .block_o    (acc_block),
      .deny_now_o (deny_now)
   );

   memfw_fault_rec #(
      .OFS_W (OFS_W)
   ) u_fault (
      .clk    (clk),
      .rst_n  (rst_n),
      .deny_i (deny_now),
      .tag_i  (cur_tag),
      .ofs_i  (acc_ofs),
      .clr_i  (port_clr),
      .flag_o (flt_flag),
      .tag_o  (flt_tag),
      .ofs_o  (flt_ofs)
   );

   p_cfg_fault_on_lock_ctrl_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (lock && reg_wr && reg_addr == A_CTRL) |=> cfg_fault);

endmodule

// File: tb/test_memfw_top.sv
`timescale 1ns/1ps
module test_memfw_top;

   localparam int unsigned NR = 3;
   localparam int unsigned GL = 4;
   localparam int unsigned WW = 6;
   localparam int unsigned OW = GL + WW;

   typedef struct {
      logic  grant;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [11:0]   reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          acc_valid = 1'b0;
   logic [OW-1:0] acc_ofs = '0;
   logic [2:0]    acc_cid = '0;
   logic          acc_write = 1'b0;
   logic          acc_sec = 1'b0;
   logic          acc_priv = 1'b0;
   logic          acc_grant;
   logic          acc_block;

   int   n_chk = 0;
   int   n_fail = 0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   memfw_top #(.NUM_RGN(NR), .GRAN_LOG2(GL), .WIN_W(WW)) i_memfw_top (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .acc_valid(acc_valid), .acc_ofs(acc_ofs), .acc_cid(acc_cid),
      .acc_write(acc_write), .acc_sec(acc_sec), .acc_priv(acc_priv),
      .acc_grant(acc_grant), .acc_block(acc_block)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      chk(reg_rdata, exp, tag);
   endtask

   // driver: one request, expected verdict pushed to the scoreboard
   task automatic acc(input logic [OW-1:0] ofs, input logic [2:0] cid, input logic w,
                      input logic s, input logic p, input logic exp_g, input string tag);
      exp_t e;
      @(negedge clk);
      acc_valid = 1'b1; acc_ofs = ofs; acc_cid = cid;
      acc_write = w; acc_sec = s; acc_priv = p;
      e.grant = exp_g; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   // monitor: verdict of the edge just passed
   always @(posedge clk) begin : mon
      exp_t e;
      #2;
      if (rst_n) begin
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if (acc_grant !== e.grant || acc_block !== !e.grant) begin
               n_fail++;
               $display("FAIL %s grant/block actual=%b%b expected=%b%b",
                        e.tag, acc_grant, acc_block, e.grant, !e.grant);
            end
         end else if (acc_grant || acc_block) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 unrequested verdict actual=%b%b expected=00", acc_grant, acc_block);
         end
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk({30'd0, acc_grant, acc_block}, 32'd0, "R1 verdict outputs");
      rd_chk(12'h000, 32'h0, "R1 control");
      rd_chk(12'h008, 32'h0, "R1 status");
      rd_chk(12'hFF0, 32'h0604_0003, "R1 hw config");
      rd_chk(12'h040, 32'h0, "R1 region1 attr");

      // R12 capture of first blocked access (no region enabled: R4)
      acc(10'h035, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, "R4 no region");
      acc(10'h3C0, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0, "R4 no region 2");
      rd_chk(12'h008, 32'h2, "R12 port fault flag");
      rd_chk(12'h020, 32'h32, "R12 first tag kept");
      rd_chk(12'h024, 32'h035, "R12 first offset kept");
      wr(12'h00C, 32'h2);
      rd_chk(12'h008, 32'h0, "R13 port flag cleared");

      // region 1: window 0x10..0x1F, cid0 read, cid1 read+write, cid1 priv
      wr(12'h044, 32'h0000_010F);
      wr(12'h048, 32'h0000_01F0);
      wr(12'h04C, 32'h0F02_0003);
      wr(12'h040, 32'h0002_0011);
      rd_chk(12'h044, 32'h0000_0100, "R2 start masked");
      rd_chk(12'h048, 32'h0000_01F0, "R2 end");
      rd_chk(12'h04C, 32'h0002_0003, "R2 cid word");
      rd_chk(12'h040, 32'h0002_0001, "R2 attr word");

      acc(10'h100, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 low bound");
      acc(10'h1FF, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 inclusive end");
      acc(10'h200, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 above end");
      acc(10'h0FF, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 below start");
      acc(10'h150, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 write not enabled");
      acc(10'h150, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, "R5 write enabled");
      acc(10'h150, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 priv missing");
      acc(10'h150, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 priv read");
      acc(10'h150, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R5 read not enabled");
      rd_chk(12'h024, 32'h200, "R13 recapture offset");
      rd_chk(12'h020, 32'h00, "R13 recapture tag");

      // region 2: window 0x18..0x2F, secure-only, all read
      wr(12'h084, 32'h0000_0180);
      wr(12'h088, 32'h0000_02F0);
      wr(12'h08C, 32'h0000_00FF);
      wr(12'h080, 32'h0000_0101);
      acc(10'h180, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R8 region1 denies");
      acc(10'h1A0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 region1 grants");
      acc(10'h250, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R7 secure ok");
      acc(10'h250, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R7 non-secure");

      // R9 encryption without secure
      wr(12'h0C0, 32'h0000_8001);
      rd_chk(12'h0C0, 32'h0, "R9 discarded");
      rd_chk(12'h008, 32'h3, "R9 config fault");
      wr(12'h0C0, 32'h0000_8101);
      rd_chk(12'h0C0, 32'h0000_8101, "R9 valid enc");
      wr(12'h00C, 32'h3);
      rd_chk(12'h008, 32'h0, "R13 both cleared");

      // R10 / R11 lock
      wr(12'h000, 32'h1);
      rd_chk(12'h000, 32'h1, "R10 lock set");
      wr(12'h000, 32'h0);
      rd_chk(12'h000, 32'h1, "R10 lock sticky");
      rd_chk(12'h008, 32'h1, "R11 ctrl write faults");
      wr(12'h040, 32'h0);
      wr(12'h044, 32'h0000_03F0);
      rd_chk(12'h040, 32'h0002_0001, "R11 attr frozen");
      rd_chk(12'h044, 32'h0000_0100, "R11 start frozen");
      acc(10'h100, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R11 checking continues");
      wr(12'h00C, 32'h1);
      rd_chk(12'h008, 32'h0, "R13 clear while locked");

      // reset clears lock and regions
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd_chk(12'h000, 32'h0, "R10 reset unlocks");
      rd_chk(12'h040, 32'h0, "R1 region cleared");
      acc(10'h100, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 empty after reset");

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule